// File: doc/BRIEF.md
# Dual-Phase ADC Recorder

This block builds one time-ordered sample record from two ADC channels. Both channels run from one clock. Channel 0 is sampled on the rising edge and channel 1 on the falling edge, so the merged stream carries two samples per clock period, half a period apart. Both channels are first registered in input flops. The channel-1 value is then moved onto the rising-edge domain, and the two are presented as an aligned pair.

A host arms the block with a record length. It then waits for a rising edge on an external trigger, which passes through a synchronizer first. From that edge the block pushes one sample pair per clock into a small on-chip buffer. The buffer is drained into a synchronous SRAM at one word per clock, at addresses that count up from zero.

When the requested number of samples has been captured and the buffer is empty, the block raises a done flag. A buffer that cannot take a pair drops the pair and sets a sticky overflow flag. Once the block is idle, the host drains the record in write order through a one-word-per-request read port.

Top module: `dual_phase_recorder`

## Requirements
- R1: After reset, `busy`, `armed`, `done`, `overflow`, `sram_we`, `sram_re` and `rd_valid` are all 0.
- R2: An `arm` pulse while idle is accepted. `armed` and `busy` are then 1 after the next edge. The same edge clears `done`, `overflow`, the SRAM write address and the readback position, and latches `rec_len`. An `arm` while busy has no effect.
- R3: While armed, capture starts only on a rising edge of `trig_in`, seen through a two-flop synchronizer. A trigger that is already high at arm time does not start a record; only a later low-to-high transition does. Let e be the first clock edge that samples `trig_in` high. The first stored word is then the channel-0 sample taken at edge e+1.
- R4: Stored words alternate strictly by time. Each channel-0 sample from a rising edge is followed by the channel-1 sample from the next falling edge, and that is followed by the channel-0 sample from the next rising edge.
- R5: A record holds floor(`rec_len`/2) sample pairs, since bit 0 of `rec_len` is ignored. After the last pair is captured and the buffer has drained, `done` becomes 1 and `busy` and `armed` become 0. `done` and `busy` are never 1 together.
- R6: SRAM writes happen only while busy, one word per clock. The write address starts at 0 for each accepted arm and rises by exactly one per write. `sram_we` and `sram_re` are never 1 together.
- R7: The buffer holds DEPTH words. If a pair does not fit, the whole pair is dropped and `overflow` is set. `overflow` stays set until the next accepted arm. With DEPTH=16, a record of 30 samples stores all 30 words without overflow. A record of 32 samples sets `overflow` and stores 30 words.
- R8: While idle, each `rd_en` reads the next stored word, starting at address 0. `rd_valid` is 1 and `rd_data` holds the word one clock later. `rd_en` is ignored while busy, and also once every stored word has been read.
- R9: Changing `rec_len` after an accepted arm does not change the length of the record being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; channel 0 is taken on its rising edge, channel 1 on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | One-cycle request to prepare a new record |
| rec_len | input | ADDR_W+1 | Record length in samples, latched on arm |
| trig_in | input | 1 | Asynchronous external trigger |
| adc0_data | input | SAMPLE_W | Channel 0 (0 degree) ADC bus |
| adc1_data | input | SAMPLE_W | Channel 1 (180 degree) ADC bus |
| sram_addr | output | ADDR_W | SRAM address, shared by writes and reads |
| sram_we | output | 1 | SRAM write strobe |
| sram_wdata | output | SAMPLE_W | SRAM write data |
| sram_re | output | 1 | SRAM read strobe, data one cycle later |
| sram_rdata | input | SAMPLE_W | SRAM read data |
| rd_en | input | 1 | Host request for the next stored word |
| rd_valid | output | 1 | `rd_data` holds a readback word |
| rd_data | output | SAMPLE_W | Readback word |
| armed | output | 1 | Waiting for a trigger edge |
| busy | output | 1 | Armed, capturing or draining |
| done | output | 1 | Last record completed |
| overflow | output | 1 | Sticky: a pair was dropped in this record |

## Verification
The assertions assume that the record length never exceeds the SRAM word count, so the write address does not wrap inside a record. They also assume the SRAM answers a read strobe with data one cycle later. The stimulus keeps every length at or below 32 samples on a 256-word SRAM, and drives the bench SRAM with a one-cycle read. Trigger pulses are raised at least two cycles after the arm and held for three cycles, so every edge is seen by the synchronizer. Each ADC bus changes half a period away from the edge that samples it.

// File: rtl/dpr_pkg.sv
// Shared types for the dual-phase recorder.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package dpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_FLUSH = 2'd3
    } acq_state_t;
endpackage

// File: rtl/dpr_pair_capture.sv
// Registers channel 0 on the rising edge and channel 1 on the falling edge,
// then aligns both onto the rising edge as one time-ordered pair.
// Assumes: both ADC buses are stable around the edge that samples them.
module dpr_pair_capture #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] ch0_in,
    input  logic [SAMPLE_W-1:0] ch1_in,
    output logic [SAMPLE_W-1:0] early_smp,
    output logic [SAMPLE_W-1:0] late_smp
);
    logic [SAMPLE_W-1:0] ch0_q;
    logic [SAMPLE_W-1:0] ch1_n;

    // Input flop for the 0 degree channel.
    always_ff @(posedge clk) begin
        if (!rst_n) ch0_q <= '0;
        else        ch0_q <= ch0_in;
    end

    // Input flop for the 180 degree channel, on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) ch1_n <= '0;
        else        ch1_n <= ch1_in;
    end

    // Retime both channels so the pair leaves together in time order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_smp <= '0;
            late_smp  <= '0;
        end else begin
            early_smp <= ch0_q;
            late_smp  <= ch1_n;
        end
    end
endmodule

// File: rtl/dpr_trig_edge.sv
// Two-flop synchronizer on the external trigger plus a rising-edge pulse.
// Assumes: trigger pulses last at least two clock periods.
module dpr_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    logic [2:0] sync_q;

    // Shift the trigger through the synchronizer and a history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], trig_async};
    end

    assign trig_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/dpr_pair_fifo.sv
// Staging buffer: takes two words per push, gives one word per pop.
// A pair that does not fit is dropped whole and reported with a pulse.
// Assumes: DEPTH is a power of two, at least 4; pop only when not empty.
module dpr_pair_fifo #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] in_first,
    input  logic [SAMPLE_W-1:0] in_second,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head,
    output logic                empty,
    output logic                drop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [SAMPLE_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]    wp, rp;
    logic [CNT_W-1:0]    fill;
    logic [CNT_W:0]      need;
    logic                take;

    // Room test counts the word leaving in the same cycle.
    always_comb begin
        need  = {1'b0, fill} + (CNT_W+1)'(2) - (CNT_W+1)'(pop);
        take  = push && (need <= (CNT_W+1)'(DEPTH));
        drop  = push && !take;
        empty = (fill == '0);
        head  = store[rp];
    end

    // Write both words of an accepted pair.
    always_ff @(posedge clk) begin
        if (take) begin
            store[wp]             <= in_first;
            store[wp + PTR_W'(1)] <= in_second;
        end
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (take) wp <= wp + PTR_W'(2);
            if (pop)  rp <= rp + PTR_W'(1);
            fill <= fill + (take ? CNT_W'(2) : CNT_W'(0)) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/dpr_record_ctrl.sv
// Record sequencer: arm, wait for trigger, capture N pairs, drain, done.
// Also owns the SRAM write address and the readback position.
// Assumes: record length never exceeds the SRAM word count.
module dpr_record_ctrl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [LEN_W-1:0]  rec_len,
    input  logic              trig_rise,
    input  logic              fifo_empty,
    input  logic              fifo_drop,
    input  logic              rd_en,
    output acq_state_t        state,
    output logic              clr,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              rd_fire,
    output logic              done,
    output logic              overflow
);
    logic [LEN_W-1:0] pair_tgt;
    logic [LEN_W-1:0] pair_cnt;

    // Decode the strobes of the current state.
    always_comb begin
        clr     = arm && (state == ST_IDLE);
        push    = (state == ST_CAPT);
        pop     = ((state == ST_CAPT) || (state == ST_FLUSH)) && !fifo_empty;
        rd_fire = rd_en && (state == ST_IDLE) && (rd_ptr != wr_addr);
    end

    // Sequence the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pair_tgt <= '0;
            pair_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (clr) begin
                    state    <= ST_ARMED;
                    pair_tgt <= rec_len >> 1;
                end
                ST_ARMED: if (trig_rise) begin
                    pair_cnt <= '0;
                    state    <= (pair_tgt == '0) ? ST_FLUSH : ST_CAPT;
                end
                ST_CAPT: begin
                    pair_cnt <= pair_cnt + LEN_W'(1);
                    if (pair_cnt == pair_tgt - LEN_W'(1)) state <= ST_FLUSH;
                end
                default: if (fifo_empty) state <= ST_IDLE;
            endcase
        end
    end

    // Write address, readback position and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr  <= '0;
            rd_ptr   <= '0;
            done     <= 1'b0;
            overflow <= 1'b0;
        end else if (clr) begin
            wr_addr  <= '0;
            rd_ptr   <= '0;
            done     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (pop)       wr_addr  <= wr_addr + ADDR_W'(1);
            if (rd_fire)   rd_ptr   <= rd_ptr + ADDR_W'(1);
            if (fifo_drop) overflow <= 1'b1;
            if ((state == ST_FLUSH) && fifo_empty) done <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_phase_recorder.sv
// Top: two-phase ADC capture, trigger, staging buffer, SRAM write and readback.
// Assumes: SRAM returns read data one cycle after sram_re; ports not shared.
module dual_phase_recorder
    import dpr_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ADDR_W   = 8,
    parameter int DEPTH    = 16,
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [LEN_W-1:0]    rec_len,
    input  logic                trig_in,
    input  logic [SAMPLE_W-1:0] adc0_data,
    input  logic [SAMPLE_W-1:0] adc1_data,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_we,
    output logic [SAMPLE_W-1:0] sram_wdata,
    output logic                sram_re,
    input  logic [SAMPLE_W-1:0] sram_rdata,
    input  logic                rd_en,
    output logic                rd_valid,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                armed,
    output logic                busy,
    output logic                done,
    output logic                overflow
);
    logic [SAMPLE_W-1:0] smp_early, smp_late, buf_head;
    logic                trig_rise, buf_empty, buf_drop;
    logic                clr, push, pop, rd_fire;
    logic [ADDR_W-1:0]   wr_addr, rd_ptr;
    acq_state_t          state;

    dpr_pair_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .ch0_in(adc0_data), .ch1_in(adc1_data),
        .early_smp(smp_early), .late_smp(smp_late)
    );

    dpr_trig_edge u_trig (
        .clk(clk), .rst_n(rst_n),
        .trig_async(trig_in), .trig_rise(trig_rise)
    );

    dpr_pair_fifo #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(push), .in_first(smp_early), .in_second(smp_late),
        .pop(pop), .head(buf_head), .empty(buf_empty), .drop(buf_drop)
    );

    dpr_record_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .rec_len(rec_len),
        .trig_rise(trig_rise), .fifo_empty(buf_empty), .fifo_drop(buf_drop),
        .rd_en(rd_en), .state(state), .clr(clr), .push(push), .pop(pop),
        .wr_addr(wr_addr), .rd_ptr(rd_ptr), .rd_fire(rd_fire),
        .done(done), .overflow(overflow)
    );

    // Share the single SRAM port: reads only happen while idle.
    always_comb begin
        sram_we    = pop;
        sram_re    = rd_fire;
        sram_addr  = rd_fire ? rd_ptr : wr_addr;
        sram_wdata = buf_head;
        rd_data    = sram_rdata;
        armed      = (state == ST_ARMED);
        busy       = (state != ST_IDLE);
    end

    // Mark the cycle in which the SRAM read data is present.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_fire;
    end
endmodule

// File: rtl/dpr_checker.sv
// Protocol checks on the recorder's ports, bound to the top module.
// Assumes: records never exceed the SRAM word count.
module dpr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              busy,
    input logic              done,
    input logic              overflow,
    input logic              sram_we,
    input logic              sram_re,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              rd_en,
    input logic              rd_valid
);
    p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sram_we);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && $past(sram_we)) |-> (sram_addr == $past(sram_addr) + ADDR_W'(1)));

    p_port_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_we, sram_re}));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(arm && !busy)) |=> overflow);

    p_rd_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && !$past(busy)));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dual_phase_recorder dpr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .done(done),
    .overflow(overflow), .sram_we(sram_we), .sram_re(sram_re),
    .sram_addr(sram_addr), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/dual_phase_recorder_test.sv
// Bench: behavioural ADC streams with embedded sequence numbers, SRAM model,
// directed corner records plus seeded random records.
module dual_phase_recorder_test;
    localparam int SW = 12;
    localparam int AW = 8;
    localparam int DP = 16;
    localparam int LW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [LW-1:0] rec_len = '0;
    logic          trig_in = 1'b0;
    logic [SW-1:0] adc0_data = '0, adc1_data = '0;
    logic [AW-1:0] sram_addr;
    logic          sram_we, sram_re;
    logic [SW-1:0] sram_wdata;
    logic [SW-1:0] sram_rdata = '0;
    logic          rd_en = 1'b0;
    logic          rd_valid;
    logic [SW-1:0] rd_data;
    logic          armed, busy, done, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int exp_waddr = 0;
    logic [SW-1:0] cur_key = '0;
    logic [SW-1:0] sram_mem [1 << AW];
    bit finished = 0;

    dual_phase_recorder #(.SAMPLE_W(SW), .ADDR_W(AW), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .rec_len(rec_len), .trig_in(trig_in),
        .adc0_data(adc0_data), .adc1_data(adc1_data),
        .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
        .sram_re(sram_re), .sram_rdata(sram_rdata),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .armed(armed), .busy(busy), .done(done), .overflow(overflow)
    );

    always #10 clk = ~clk;

    function automatic logic [SW-1:0] enc(int seq);
        return SW'(seq) ^ cur_key;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ADC streams: even sequence numbers on channel 0 (rising edge),
    // odd ones on channel 1 (falling edge), so time order equals count order.
    always @(posedge clk) begin
        cyc = cyc + 1;
        adc1_data <= enc(2 * cyc + 1);
    end
    always @(negedge clk) adc0_data <= enc(2 * (cyc + 1));

    // SRAM model with one-cycle read, and write-address monitor (R6).
    always @(posedge clk) begin
        if (sram_we) begin
            sram_mem[sram_addr] <= sram_wdata;
            if (rst_n) begin
                check(int'(sram_addr) == exp_waddr, "R6 write address", sram_addr, exp_waddr);
                exp_waddr = exp_waddr + 1;
            end
        end
        if (sram_re) sram_rdata <= sram_mem[sram_addr];
    end

    // Arm, optionally pre-raise trigger, fire trigger, optionally disturb, wait done.
    task automatic run_record(int len, int dly, bit pre_high, bit disturb, output int first_seq);
        int tc;
        @(negedge clk);
        cur_key   = SW'($urandom);
        exp_waddr = 0;
        if (pre_high) begin
            trig_in = 1'b1;
            repeat (3) @(negedge clk);
        end
        rec_len = LW'(len);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check(armed && busy, "R2 armed after arm", {armed, busy}, 3);
        check(!done && !overflow, "R2 flags cleared", {done, overflow}, 0);
        if (pre_high) begin
            repeat (8) @(negedge clk);
            check(armed && exp_waddr == 0, "R3 high trigger at arm ignored", armed, 1);
            trig_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (dly) @(negedge clk);
        trig_in = 1'b1;
        tc = cyc + 1;
        first_seq = 2 * tc + 2;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        if (disturb) begin
            arm = 1'b1;
            rd_en = 1'b1;
            rec_len = LW'(len + 40);
            @(negedge clk);
            arm = 1'b0;
            rd_en = 1'b0;
            check(!rd_valid, "R8 read while busy ignored", rd_valid, 0);
            check(busy && !armed, "R2 arm while busy ignored", {busy, armed}, 2);
            // A second trigger edge during capture must not restart anything.
            trig_in = 1'b1;
            repeat (3) @(negedge clk);
            trig_in = 1'b0;
        end
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
        check(done && !busy && !armed, "R5 done and idle", {done, busy, armed}, 4);
    endtask

    // Drain n words; expect consecutive sequence numbers from first_seq,
    // then one extra request that must be ignored (R8).
    task automatic read_record(int n, int first_seq, string tag);
        @(negedge clk);
        rd_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(rd_valid && rd_data == enc(first_seq + i), tag, rd_data, enc(first_seq + i));
        end
        @(negedge clk);
        rd_en = 1'b0;
        check(!rd_valid, "R8 read past end ignored", rd_valid, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int fs, len;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        check(!busy && !armed && !done && !overflow, "R1 reset flags", {busy, armed, done, overflow}, 0);
        check(!sram_we && !sram_re && !rd_valid, "R1 reset strobes", {sram_we, sram_re, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 after release", {busy, done}, 0);

        // Nothing stored yet: a read request must not produce data (R8).
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check(!rd_valid, "R8 empty record read ignored", rd_valid, 0);

        // Directed: a 20-sample record, content and ordering (R3, R4).
        run_record(20, 2, 0, 0, fs);
        check(!overflow, "R7 no overflow at 20", overflow, 0);
        read_record(20, fs, "R4 merged order len 20");

        // Directed: minimum length.
        run_record(2, 3, 0, 0, fs);
        read_record(2, fs, "R5 minimum length record");

        // Directed: odd length rounds down (R5).
        run_record(21, 4, 0, 0, fs);
        read_record(20, fs, "R5 odd length rounds down");

        // Directed: trigger already high at arm (R3).
        run_record(10, 2, 1, 0, fs);
        read_record(10, fs, "R3 later edge starts record");

        // Directed: arm/read/length change/second trigger mid-capture (R2, R8, R9).
        run_record(24, 2, 0, 1, fs);
        read_record(24, fs, "R9 length latched at arm");

        // Directed: largest length that fits the buffer (R7).
        run_record(30, 2, 0, 0, fs);
        check(!overflow, "R7 no overflow at 30", overflow, 0);
        read_record(30, fs, "R7 full 30-sample record");

        // Directed: overflow drops the final pair and sticks (R7).
        run_record(32, 2, 0, 0, fs);
        check(overflow, "R7 overflow at 32", overflow, 1);
        repeat (5) @(negedge clk);
        check(overflow, "R7 overflow sticky while idle", overflow, 1);
        read_record(30, fs, "R7 stored words after overflow");

        // Random records; the arm inside run_record also checks the overflow clear.
        for (int k = 0; k < 8; k++) begin
            len = 2 + int'($urandom % 29);
            run_record(len, 2 + int'($urandom % 5), 0, (k % 2) == 1, fs);
            check(!overflow, "R7 random record no overflow", overflow, 0);
            read_record(2 * (len / 2), fs, "R4 random record content");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule